// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. It walks a two-level page hierarchy kept in memory: a directory of 1024 entries, then a table of 1024 entries. Each entry is 32 bits wide. The walker takes one request at a time. A request carries the linear address and three flags: write, user and probe. Four control inputs apply to the request: paging enable, large-page enable, directory base and an address mask.

The walker reaches memory through a single-outstanding port that does 32-bit reads and writes. While it walks, it sets the accessed and dirty bits in the entries and writes each changed entry back. A directory entry marked as a large page maps 4 MB directly, with no table lookup. The result is either a physical address with a one-cycle `done` pulse, or a fault with an error code and the faulting address, marked by a one-cycle `fault` pulse.

In probe mode the walker makes the same lookups but leaves memory untouched. A missing mapping then comes back as an all-ones address instead of a fault. The caller issues a request while `ready` is high and waits for `done` or `fault`.

Top module: `pt_walker`

## Requirements
- R1: With paging disabled, an accepted request gives `done` in the next cycle, with `phys_addr` equal to the linear address and no memory access.
- R2: The directory entry is read at `((dir_base & 0xFFFFF000) + lin[31:22]*4) & addr_mask`. Both the base and the mask are sampled when the request is accepted.
- R3: The table entry is read at `((dir_entry & 0xFFFFF000) + lin[21:12]*4) & addr_mask`.
- R4: A 4 KB mapping returns `{table_entry[31:12], lin[11:0]}`.
- R5: A directory entry with bit 7 set, while `big_en` is high, maps 4 MB. It returns `{dir_entry[31:22], lin[21:0]}` and no table is read. When `big_en` is low, bit 7 is ignored and the entry points to a table.
- R6: An entry with bit 0 (present) clear ends a non-probe walk with a fault. `fault_addr` receives the linear address. `fault_code` bit 0 is 0, bit 1 is the write flag and bit 2 is the user flag.
- R7: An entry whose bit 5 (accessed) is clear is written back with bit 5 set. On a write request the leaf entry also gets bit 6 (dirty) set. A directory entry that points to a table never gets bit 6.
- R8: An entry is written back only when one of its bits changes. An already-updated entry costs just its read.
- R9: A probe request writes nothing. A missing mapping in probe mode gives `done` with `phys_addr` = 0xFFFFFFFF, raises no fault and leaves `fault_addr` unchanged.
- R10: `done` and `fault` are single-cycle pulses and never high together. `ready` is high only when the walker is idle. A request offered while the walker is busy is ignored.
- R11: Once `mem_req` is raised, it is held together with `mem_addr`, `mem_we` and `mem_wdata` until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request, taken when `ready` is high |
| req_lin | input | 32 | Linear address to translate |
| req_write | input | 1 | Request is a write access |
| req_user | input | 1 | Request comes from user level |
| req_probe | input | 1 | Translate without side effects |
| ready | output | 1 | Walker idle, able to accept a request |
| pg_en | input | 1 | Paging enable |
| big_en | input | 1 | Large-page enable |
| dir_base | input | 32 | Directory base address |
| addr_mask | input | 32 | Mask applied to every entry address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete, read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle pulse: translation finished |
| phys_addr | output | 32 | Translated address, held after `done` |
| fault | output | 1 | One-cycle pulse: translation failed |
| fault_code | output | 3 | Error code of the last fault |
| fault_addr | output | 32 | Linear address of the last fault |

## Verification
With paging off, `done` is due exactly one cycle after the edge that accepts the request. In a walk, `done` or `fault` follows one cycle after the edge that delivers the last `mem_ack`. The bench drives and samples on falling edges, counts falling edges from acceptance until a result pulse appears, and checks the flat-map latency against exactly one. The bench memory model acknowledges each access one cycle after it starts and logs its address and direction. From that log, the exact sequence of reads and write-backs is compared with the one the requirements call for.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int VA_W   = 32;
    localparam int ENT_W  = 32;
    localparam int OFF_W  = 12;
    localparam int IDX_W  = 10;
    localparam int BIG_W  = OFF_W + IDX_W;
    localparam int ENT_SH = 2;
    localparam int ERR_W  = 3;

    localparam int B_PRES  = 0;
    localparam int B_ACC   = 5;
    localparam int B_DIRTY = 6;
    localparam int B_SIZE  = 7;

    typedef logic [VA_W-1:0]  va_t;
    typedef logic [ENT_W-1:0] ent_t;
    typedef logic [ERR_W-1:0] err_t;

    localparam va_t PAGE_MASK = {{(VA_W-OFF_W){1'b1}}, {OFF_W{1'b0}}};
    localparam va_t BIG_MASK  = {{(VA_W-BIG_W){1'b1}}, {BIG_W{1'b0}}};
    localparam va_t IDX_MASK  = va_t'((1 << IDX_W) - 1);

    typedef enum logic [2:0] {
        ST_IDLE, ST_RD_DIR, ST_WB_DIR, ST_RD_TBL, ST_WB_TBL, ST_DONE, ST_FAULT
    } walk_st_e;

    typedef struct packed {
        va_t  lin;
        logic write;
        logic user;
        logic probe;
    } walk_req_t;

    function automatic va_t dir_slot(va_t base, va_t lin, va_t mask);
        return ((base & PAGE_MASK) + ((lin >> BIG_W) << ENT_SH)) & mask;
    endfunction

    function automatic va_t tbl_slot(ent_t pde, va_t lin, va_t mask);
        return ((pde & PAGE_MASK) + (((lin >> OFF_W) & IDX_MASK) << ENT_SH)) & mask;
    endfunction

    function automatic va_t big_phys(ent_t pde, va_t lin);
        return (pde & BIG_MASK) | (lin & ~BIG_MASK);
    endfunction

    function automatic va_t small_phys(ent_t pte, va_t lin);
        return (pte & PAGE_MASK) | (lin & ~PAGE_MASK);
    endfunction

    function automatic err_t mk_err(logic write, logic user);
        return {user, write, 1'b0};
    endfunction

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
(
    input  va_t  base,
    input  va_t  new_lin,
    input  va_t  new_mask,
    input  va_t  walk_lin,
    input  va_t  walk_mask,
    input  ent_t ent,
    output va_t  dir_ea,
    output va_t  tbl_ea,
    output va_t  big_pa,
    output va_t  small_pa
);
    assign dir_ea   = dir_slot(base, new_lin, new_mask);
    assign tbl_ea   = tbl_slot(ent, walk_lin, walk_mask);
    assign big_pa   = big_phys(ent, walk_lin);
    assign small_pa = small_phys(ent, walk_lin);
endmodule

// File: rtl/ptw_entry_upd.sv
module ptw_entry_upd
    import ptw_pkg::*;
(
    input  ent_t entry,
    input  logic leaf,
    input  logic write,
    output logic present,
    output logic big,
    output ent_t updated,
    output logic changed
);
    always_comb begin
        updated        = entry;
        updated[B_ACC] = 1'b1;
        if (leaf && write)
            updated[B_DIRTY] = 1'b1;
    end

    assign present = entry[B_PRES];
    assign big     = entry[B_SIZE];
    assign changed = (updated != entry);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [31:0] req_lin,
    input  logic        req_write,
    input  logic        req_user,
    input  logic        req_probe,
    output logic        ready,
    input  logic        pg_en,
    input  logic        big_en,
    input  logic [31:0] dir_base,
    input  logic [31:0] addr_mask,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    output logic        done,
    output logic [31:0] phys_addr,
    output logic        fault,
    output logic [2:0]  fault_code,
    output logic [31:0] fault_addr
);
    walk_st_e  st;
    walk_req_t rq;
    va_t       mask_q, ea_q, next_ea_q;
    ent_t      ent_q;
    logic      big_en_q, large_q;

    va_t  dir_ea, tbl_ea, big_pa, small_pa;
    logic e_present, e_big, e_changed, e_leaf, dir_large, wb_need;
    ent_t e_upd;

    ptw_addr_gen u_addr (
        .base(dir_base), .new_lin(req_lin), .new_mask(addr_mask),
        .walk_lin(rq.lin), .walk_mask(mask_q), .ent(mem_rdata),
        .dir_ea(dir_ea), .tbl_ea(tbl_ea), .big_pa(big_pa), .small_pa(small_pa)
    );

    assign dir_large = e_big && big_en_q;
    assign e_leaf    = (st == ST_RD_TBL) || dir_large;

    ptw_entry_upd u_upd (
        .entry(mem_rdata), .leaf(e_leaf), .write(rq.write),
        .present(e_present), .big(e_big), .updated(e_upd), .changed(e_changed)
    );

    assign wb_need   = e_changed && !rq.probe;
    assign ready     = (st == ST_IDLE);
    assign done      = (st == ST_DONE);
    assign fault     = (st == ST_FAULT);
    assign mem_req   = (st == ST_RD_DIR) || (st == ST_WB_DIR) ||
                       (st == ST_RD_TBL) || (st == ST_WB_TBL);
    assign mem_we    = (st == ST_WB_DIR) || (st == ST_WB_TBL);
    assign mem_addr  = ea_q;
    assign mem_wdata = mem_we ? ent_q : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            rq         <= '0;
            mask_q     <= '0;
            ea_q       <= '0;
            next_ea_q  <= '0;
            ent_q      <= '0;
            big_en_q   <= 1'b0;
            large_q    <= 1'b0;
            phys_addr  <= '0;
            fault_code <= '0;
            fault_addr <= '0;
        end else begin
            case (st)
                ST_IDLE: if (req_valid) begin
                    rq       <= '{lin: req_lin, write: req_write, user: req_user, probe: req_probe};
                    mask_q   <= addr_mask;
                    big_en_q <= big_en;
                    if (!pg_en) begin
                        phys_addr <= req_lin;
                        st        <= ST_DONE;
                    end else begin
                        ea_q <= dir_ea;
                        st   <= ST_RD_DIR;
                    end
                end
                ST_RD_DIR, ST_RD_TBL: if (mem_ack) begin
                    if (!e_present) begin
                        if (rq.probe) begin
                            phys_addr <= '1;
                            st        <= ST_DONE;
                        end else begin
                            fault_addr <= rq.lin;
                            fault_code <= mk_err(rq.write, rq.user);
                            st         <= ST_FAULT;
                        end
                    end else if (st == ST_RD_DIR) begin
                        ent_q     <= e_upd;
                        large_q   <= dir_large;
                        next_ea_q <= tbl_ea;
                        if (dir_large)
                            phys_addr <= big_pa;
                        if (wb_need)
                            st <= ST_WB_DIR;
                        else if (dir_large)
                            st <= ST_DONE;
                        else begin
                            ea_q <= tbl_ea;
                            st   <= ST_RD_TBL;
                        end
                    end else begin
                        ent_q     <= e_upd;
                        phys_addr <= small_pa;
                        st        <= wb_need ? ST_WB_TBL : ST_DONE;
                    end
                end
                ST_WB_DIR: if (mem_ack) begin
                    if (large_q)
                        st <= ST_DONE;
                    else begin
                        ea_q <= next_ea_q;
                        st   <= ST_RD_TBL;
                    end
                end
                ST_WB_TBL: if (mem_ack)
                    st <= ST_DONE;
                default:
                    st <= ST_IDLE;
            endcase
        end
    end

    // R10
    done_fault_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(done && fault));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    fault_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        fault |=> !fault);

    // R11
    port_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));

    // R9
    probe_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> !rq.probe);

    // R1
    flat_map_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && req_valid && !pg_en) |=> (done && phys_addr == $past(req_lin)));

    // R6
    fault_code_chk: assert property (@(posedge clk) disable iff (rst)
        fault |-> !fault_code[0]);

endmodule

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        req_valid = 0, req_write = 0, req_user = 0, req_probe = 0;
    logic [31:0] req_lin = '0;
    logic        pg_en = 0, big_en = 0;
    logic [31:0] dir_base = 32'h1000, addr_mask = 32'hFFFF_FFFF;
    logic        ready, mem_req, mem_we, mem_ack, done, fault;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, phys_addr, fault_addr;
    logic [2:0]  fault_code;

    pt_walker u_pt_walker (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_lin(req_lin),
        .req_write(req_write), .req_user(req_user), .req_probe(req_probe),
        .ready(ready), .pg_en(pg_en), .big_en(big_en), .dir_base(dir_base),
        .addr_mask(addr_mask), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .done(done), .phys_addr(phys_addr),
        .fault(fault), .fault_code(fault_code), .fault_addr(fault_addr)
    );

    // memory model: one-cycle ack, access log
    logic [31:0] mem [0:4095];
    logic        ack_q = 0;
    logic [31:0] rdata_q = '0;
    int          log_n = 0;
    logic [31:0] log_addr [0:63];
    logic        log_we   [0:63];
    assign mem_ack   = ack_q;
    assign mem_rdata = rdata_q;

    always @(posedge clk) begin
        if (rst) ack_q <= 1'b0;
        else if (mem_req && !ack_q) begin
            ack_q   <= 1'b1;
            rdata_q <= mem[mem_addr[13:2]];
            if (mem_we) mem[mem_addr[13:2]] = mem_wdata;
            log_addr[log_n % 64] <= mem_addr;
            log_we[log_n % 64]   <= mem_we;
            log_n <= log_n + 1;
        end else ack_q <= 1'b0;
    end

    int checks = 0, errors = 0;
    int base_n, n_acc, lat;
    logic got_done, got_fault;
    logic [31:0] got_pa;

    function automatic int wi(logic [31:0] a);
        return int'(a[13:2]);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_req(logic [31:0] lin, logic wr, logic us, logic pr);
        @(negedge clk);
        req_valid = 1; req_lin = lin; req_write = wr; req_user = us; req_probe = pr;
        base_n = log_n;
        @(negedge clk);
        req_valid = 0;
        lat = 1;
        while (!(done || fault) && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        got_done = done; got_fault = fault; got_pa = phys_addr;
        n_acc = log_n - base_n;
        chk("R10 result pulse seen", 32'(got_done || got_fault), 32'd1);
    endtask

    task automatic t_reset;
        chk("R10 ready after reset", 32'(ready), 32'd1);
        chk("R10 done low after reset", 32'(done), 32'd0);
        chk("R10 fault low after reset", 32'(fault), 32'd0);
        chk("R11 no mem_req after reset", 32'(mem_req), 32'd0);
    endtask

    task automatic t_flat;
        pg_en = 0;
        do_req(32'hDEAD_BEEF, 1, 1, 0);
        chk("R1 latency", lat, 1);
        chk("R1 phys", got_pa, 32'hDEAD_BEEF);
        chk("R1 no memory access", n_acc, 0);
        pg_en = 1;
    endtask

    task automatic t_small_first;
        do_req(32'h0040_3ABC, 0, 0, 0);
        chk("R4 phys 4K", got_pa, 32'hABCD_EABC);
        chk("R7 access count", n_acc, 4);
        chk("R2 dir addr", log_addr[base_n % 64], 32'h1004);
        chk("R7 dir write-back", 32'(log_we[(base_n+1) % 64]), 32'd1);
        chk("R3 tbl addr", log_addr[(base_n+2) % 64], 32'h200C);
        chk("R7 dir accessed", mem[wi(32'h1004)], 32'h0000_2021);
        chk("R7 tbl accessed", mem[wi(32'h200C)], 32'hABCD_E021);
    endtask

    task automatic t_small_again;
        do_req(32'h0040_3ABC, 0, 1, 0);
        chk("R8 no write-back", n_acc, 2);
        chk("R4 phys again", got_pa, 32'hABCD_EABC);
    endtask

    task automatic t_small_write;
        do_req(32'h0040_3ABC, 1, 0, 0);
        chk("R8 write access count", n_acc, 3);
        chk("R7 tbl dirty", mem[wi(32'h200C)], 32'hABCD_E061);
        chk("R7 dir not dirty", mem[wi(32'h1004)], 32'h0000_2021);
    endtask

    task automatic t_large;
        big_en = 1;
        do_req(32'h00C1_2345, 1, 0, 0);
        chk("R5 phys 4M", got_pa, 32'h1281_2345);
        chk("R5 no table read", n_acc, 2);
        chk("R7 large dirty", mem[wi(32'h100C)], 32'h1280_00E1);
        big_en = 0;
    endtask

    task automatic t_large_off;
        do_req(32'h00C1_2345, 0, 0, 0);
        chk("R5 size bit ignored phys", got_pa, 32'h0005_5345);
        chk("R3 tbl addr from entry", log_addr[(base_n+1) % 64], 32'h1280_0048);
        chk("R8 access count", n_acc, 3);
    endtask

    task automatic t_fault_dir;
        do_req(32'h0800_0000, 1, 1, 0);
        chk("R6 fault dir", 32'(got_fault), 32'd1);
        chk("R6 code dir", 32'(fault_code), 32'h6);
        chk("R6 addr dir", fault_addr, 32'h0800_0000);
    endtask

    task automatic t_fault_tbl;
        do_req(32'h0040_5000, 0, 0, 0);
        chk("R6 fault tbl", 32'(got_fault), 32'd1);
        chk("R6 code tbl", 32'(fault_code), 32'h0);
        chk("R6 addr tbl", fault_addr, 32'h0040_5000);
    endtask

    task automatic t_probe;
        int wr_cnt;
        do_req(32'h0040_7123, 1, 0, 1);
        wr_cnt = 0;
        for (int i = 0; i < n_acc; i++) if (log_we[(base_n+i) % 64]) wr_cnt++;
        chk("R9 probe phys", got_pa, 32'h7777_7123);
        chk("R9 probe no writes", wr_cnt, 0);
        chk("R9 entry untouched", mem[wi(32'h201C)], 32'h7777_7001);
        do_req(32'h0800_0000, 0, 1, 1);
        chk("R9 probe invalid done", 32'(got_done), 32'd1);
        chk("R9 probe no fault", 32'(got_fault), 32'd0);
        chk("R9 probe invalid phys", got_pa, 32'hFFFF_FFFF);
        chk("R9 fault addr kept", fault_addr, 32'h0040_5000);
    endtask

    task automatic t_mask;
        dir_base = 32'h0000_5000; addr_mask = 32'hFFFF_BFFF;
        do_req(32'h0040_3ABC, 0, 0, 0);
        chk("R2 masked dir addr", log_addr[base_n % 64], 32'h1004);
        chk("R2 masked phys", got_pa, 32'hABCD_EABC);
        dir_base = 32'h1000; addr_mask = 32'hFFFF_FFFF;
    endtask

    task automatic t_busy;
        int extra;
        @(negedge clk);
        req_valid = 1; req_lin = 32'h0040_3ABC; req_write = 0; req_user = 0; req_probe = 0;
        @(negedge clk);
        req_lin = 32'hDEAD_BEEF;
        chk("R10 ready low while busy", 32'(ready), 32'd0);
        @(negedge clk);
        req_valid = 0;
        lat = 0;
        while (!done && lat < 200) begin @(negedge clk); lat++; end
        chk("R10 busy request ignored", phys_addr, 32'hABCD_EABC);
        extra = 0;
        for (int i = 0; i < 6; i++) begin @(negedge clk); if (done) extra++; end
        chk("R10 single done", extra, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        mem[wi(32'h1004)] = 32'h0000_2001;
        mem[wi(32'h200C)] = 32'hABCD_E001;
        mem[wi(32'h201C)] = 32'h7777_7001;
        mem[wi(32'h100C)] = 32'h1280_0081;
        mem[18]           = 32'h0005_5001;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_flat();
        t_small_first();
        t_small_again();
        t_small_write();
        t_large();
        t_large_off();
        t_fault_dir();
        t_fault_tbl();
        t_probe();
        t_mask();
        t_busy();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule